// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block sits on the memory side of an asynchronous DRAM bus. It samples the row strobe, the two byte-lane column strobes, the write strobe and the output-enable strobe with a fast system clock. From the order of their edges it works out what kind of cycle the controller is running. On every row-strobe fall it reports the cycle kind. It holds the row and column addresses and keeps a refresh row counter. For each byte lane it produces a tristate enable and a one-clock write strobe. A storage model or a bridge to another memory uses these outputs to serve the access.

All strobes are active low and pass through a two-flop synchronizer. The address bus passes through a matching two-stage pipe, so addresses and strobes stay aligned. The outputs are registered once more, so every output follows a strobe change by three clock edges. The two column strobes are merged into one internal column strobe. Each byte lane still gates its own tristate enable and write strobe. Lane 0 follows the lower column strobe and lane 1 follows the upper one.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, and while every strobe is high, `lane_drive`, `lane_write`, `cyc_valid`, `col_load`, `cas_merged` and `cycle_busy` are 0, and `cyc_kind` and `refresh_row` are 0.
- R2: `cas_merged` is 1 from the first column strobe going low until the last column strobe returns high.
- R3: When the row strobe falls with both column strobes high, `cyc_valid` pulses for one clock. At the same time `cyc_kind` becomes 1 (row opened from the address bus) and `row_out` takes the address present at that fall.
- R4: When the row strobe falls with a column strobe already low and no access open, `cyc_kind` becomes 2 (counter refresh) and `row_out` equals `refresh_row`, whatever the address bus holds. No lane drives, even with OE low and WE high.
- R5: `refresh_row` increases by one when the row strobe rises at the end of a kind-2 or kind-3 cycle. It wraps from 2^ADDR_W-1 to 0 and changes at no other time.
- R6: If the column strobes are held low through a read while the row strobe goes high and low again, `cyc_kind` becomes 3 (hidden refresh) and `row_out` equals `refresh_row`. The read lanes keep driving the whole time.
- R7: In an open access, lane i drives only while its own column strobe is low, WE is high and OE is low. Raising OE releases the lane while its column strobe is still low.
- R8: In an open access with the row strobe low, each fall of the merged column strobe pulses `col_load` for one clock and loads `col_out` from the address bus.
- R9: In an open access with the row strobe low, `lane_write[i]` pulses for one clock once lane i's column strobe and WE are both low. The pulse comes from whichever of the two falls last, and the lane does not drive at the same time.
- R10: `cycle_busy` is 1 while any strobe among row and column is low, and is 0 only once all three are high. A row cycle with no column strobe drives no lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| cyc_valid | output | 1 | One-clock pulse at each row-strobe fall |
| cyc_kind | output | 2 | 1 row open, 2 counter refresh, 3 hidden refresh |
| row_out | output | ADDR_W | Row of the current row cycle |
| col_out | output | ADDR_W | Last loaded column |
| col_load | output | 1 | One-clock pulse when a column is loaded |
| refresh_row | output | ADDR_W | Refresh row counter |
| lane_drive | output | 2 | Per-lane tristate enable |
| lane_write | output | 2 | Per-lane one-clock write strobe |
| cas_merged | output | 1 | Merged column strobe, active high |
| cycle_busy | output | 1 | A row or column strobe is low |

## Verification
A hidden refresh puts two functions in one window: the refresh counter supplies the row and then steps, while a read lane keeps driving. The bench provokes this by holding the column strobes and OE low across a row-strobe toggle. At each step it checks that `lane_drive` keeps the read mask, that `cyc_kind` reads 3 with `row_out` equal to the model counter, and that the counter steps only at the final row-strobe rise. Random read, write, row-only and counter-refresh cycles run between these cases, so the access-open flag is tested both for following and for not following into a refresh.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_ROW    = 2'd1,
    KIND_CBR    = 2'd2,
    KIND_HIDDEN = 2'd3
  } cyc_kind_e;

  localparam int STROBE_W = 5;
  localparam int SB_RAS   = 0;
  localparam int SB_LCAS  = 1;
  localparam int SB_UCAS  = 2;
  localparam int SB_WE    = 3;
  localparam int SB_OE    = 4;
endpackage

// File: rtl/dram_dec_rstsync.sv
module dram_dec_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/dram_dec_sync.sv
module dram_dec_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      dout   <= RST_VAL;
    end else begin
      meta_q <= din;
      dout   <= meta_q;
    end
  end
endmodule

// File: rtl/dram_dec_ctrl.sv
module dram_dec_ctrl
  import dram_dec_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_s,
  input  logic [LANES-1:0]  cas_s,
  input  logic [ADDR_W-1:0] addr_s,
  output logic              access_q,
  output logic              cyc_valid_q,
  output cyc_kind_e         kind_q,
  output logic [ADDR_W-1:0] row_q,
  output logic [ADDR_W-1:0] col_q,
  output logic              col_load_q,
  output logic [ADDR_W-1:0] ref_ctr_q,
  output logic              cas_int_q,
  output logic              busy_q
);
  logic ras_d_q, cas_any_d_q, ref_pend_q;

  logic              ras_fall, ras_rise, cas_any, cas_fall;
  logic              access_nxt, cyc_valid_nxt, col_load_nxt, ref_pend_nxt;
  cyc_kind_e         kind_nxt;
  logic [ADDR_W-1:0] row_nxt, col_nxt, ref_ctr_nxt;

  always_comb begin
    ras_fall = ras_d_q & ~ras_s;
    ras_rise = ~ras_d_q & ras_s;
    cas_any  = ~&cas_s;
    cas_fall = cas_any & ~cas_any_d_q;

    access_nxt    = access_q;
    cyc_valid_nxt = 1'b0;
    kind_nxt      = kind_q;
    row_nxt       = row_q;
    col_nxt       = col_q;
    col_load_nxt  = 1'b0;
    ref_pend_nxt  = ref_pend_q;
    ref_ctr_nxt   = ref_ctr_q;

    if (ras_fall) begin
      cyc_valid_nxt = 1'b1;
      if (!cas_any) begin
        kind_nxt   = KIND_ROW;
        row_nxt    = addr_s;
        access_nxt = 1'b1;
      end else begin
        kind_nxt     = access_q ? KIND_HIDDEN : KIND_CBR;
        row_nxt      = ref_ctr_q;
        ref_pend_nxt = 1'b1;
      end
    end else if (ras_s && !cas_any) begin
      access_nxt = 1'b0;
    end

    if (ras_rise && ref_pend_q) begin
      ref_ctr_nxt  = ref_ctr_q + 1'b1;
      ref_pend_nxt = 1'b0;
    end

    if (cas_fall && access_q && !ras_s) begin
      col_nxt      = addr_s;
      col_load_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_d_q     <= 1'b1;
      cas_any_d_q <= 1'b0;
      ref_pend_q  <= 1'b0;
      access_q    <= 1'b0;
      cyc_valid_q <= 1'b0;
      kind_q      <= KIND_NONE;
      row_q       <= '0;
      col_q       <= '0;
      col_load_q  <= 1'b0;
      ref_ctr_q   <= '0;
      cas_int_q   <= 1'b0;
      busy_q      <= 1'b0;
    end else begin
      ras_d_q     <= ras_s;
      cas_any_d_q <= cas_any;
      ref_pend_q  <= ref_pend_nxt;
      access_q    <= access_nxt;
      cyc_valid_q <= cyc_valid_nxt;
      kind_q      <= kind_nxt;
      row_q       <= row_nxt;
      col_q       <= col_nxt;
      col_load_q  <= col_load_nxt;
      ref_ctr_q   <= ref_ctr_nxt;
      cas_int_q   <= cas_any;
      busy_q      <= ~ras_s | cas_any;
    end
  end

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid_q |=> !cyc_valid_q);

  assert_refresh_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid_q && kind_q != KIND_ROW) |-> (row_q == ref_ctr_q));

  assert_counter_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ctr_q != $past(ref_ctr_q)) |-> (ref_ctr_q == ADDR_W'($past(ref_ctr_q) + 1'b1)));

  assert_col_in_cas_R8: assert property (@(posedge clk) disable iff (!rst_n)
    col_load_q |-> cas_int_q);

  assert_valid_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid_q |-> busy_q);

  assert_merged_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cas_int_q |-> busy_q);
endmodule

// File: rtl/dram_dec_lane.sv
module dram_dec_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic access,
  input  logic ras_s,
  input  logic cas_s,
  input  logic we_s,
  input  logic oe_s,
  output logic drive_q,
  output logic write_q
);
  logic wr_prev_q;
  logic wr_cond, drive_nxt, write_nxt;

  always_comb begin
    drive_nxt = access & ~cas_s & we_s & ~oe_s;
    wr_cond   = access & ~ras_s & ~cas_s & ~we_s;
    write_nxt = wr_cond & ~wr_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q   <= 1'b0;
      write_q   <= 1'b0;
      wr_prev_q <= 1'b0;
    end else begin
      drive_q   <= drive_nxt;
      write_q   <= write_nxt;
      wr_prev_q <= wr_cond;
    end
  end

  assert_drive_write_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_q && write_q));

  assert_write_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    write_q |=> !write_q);
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dram_dec_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              lcas_n,
  input  logic              ucas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              cyc_valid,
  output logic [1:0]        cyc_kind,
  output logic [ADDR_W-1:0] row_out,
  output logic [ADDR_W-1:0] col_out,
  output logic              col_load,
  output logic [ADDR_W-1:0] refresh_row,
  output logic [1:0]        lane_drive,
  output logic [1:0]        lane_write,
  output logic              cas_merged,
  output logic              cycle_busy
);
  localparam int LANES = 2;

  logic                rst_n_i;
  logic [STROBE_W-1:0] strobe_raw, strobe_s;
  logic [ADDR_W-1:0]   addr_s;
  logic [LANES-1:0]    cas_s;
  logic                access;
  cyc_kind_e           kind;

  assign strobe_raw = {oe_n, we_n, ucas_n, lcas_n, ras_n};
  assign cas_s      = {strobe_s[SB_UCAS], strobe_s[SB_LCAS]};
  assign cyc_kind   = kind;

  dram_dec_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  dram_dec_sync #(.W(STROBE_W), .RST_VAL({STROBE_W{1'b1}})) u_strobe_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .din   (strobe_raw),
    .dout  (strobe_s)
  );

  dram_dec_sync #(.W(ADDR_W), .RST_VAL({ADDR_W{1'b0}})) u_addr_pipe (
    .clk   (clk),
    .rst_n (rst_n_i),
    .din   (addr),
    .dout  (addr_s)
  );

  dram_dec_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .ras_s       (strobe_s[SB_RAS]),
    .cas_s       (cas_s),
    .addr_s      (addr_s),
    .access_q    (access),
    .cyc_valid_q (cyc_valid),
    .kind_q      (kind),
    .row_q       (row_out),
    .col_q       (col_out),
    .col_load_q  (col_load),
    .ref_ctr_q   (refresh_row),
    .cas_int_q   (cas_merged),
    .busy_q      (cycle_busy)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dram_dec_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n_i),
      .access  (access),
      .ras_s   (strobe_s[SB_RAS]),
      .cas_s   (cas_s[g]),
      .we_s    (strobe_s[SB_WE]),
      .oe_s    (strobe_s[SB_OE]),
      .drive_q (lane_drive[g]),
      .write_q (lane_write[g])
    );
  end

  assert_cbr_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cyc_valid && kind == KIND_CBR) |-> (lane_drive == 2'b00));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n_i)
    !cycle_busy |-> (lane_write == 2'b00 && !cas_merged));
endmodule

// File: tb/dram_cycle_decoder_tb_top.sv
`timescale 1ns/1ps
module dram_cycle_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ras_n, lcas_n, ucas_n, we_n, oe_n;
  logic [9:0] addr;
  logic       cyc_valid, col_load, cas_merged, cycle_busy;
  logic [1:0] cyc_kind, lane_drive, lane_write;
  logic [9:0] row_out, col_out, refresh_row;

  int checks = 0;
  int errors = 0;
  int mon_cyc = 0, mon_col = 0, mon_wr0 = 0, mon_wr1 = 0;
  logic [1:0] mon_kind = 2'd0;
  logic [9:0] mon_row = 10'd0;
  logic [9:0] exp_ctr = 10'd0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dram_cycle_decoder #(.ADDR_W(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
    .row_out(row_out), .col_out(col_out), .col_load(col_load), .refresh_row(refresh_row),
    .lane_drive(lane_drive), .lane_write(lane_write), .cas_merged(cas_merged),
    .cycle_busy(cycle_busy)
  );

  always @(posedge clk) begin
    if (cyc_valid) begin
      mon_cyc  <= mon_cyc + 1;
      mon_kind <= cyc_kind;
      mon_row  <= row_out;
    end
    if (col_load)      mon_col <= mon_col + 1;
    if (lane_write[0]) mon_wr0 <= mon_wr0 + 1;
    if (lane_write[1]) mon_wr1 <= mon_wr1 + 1;
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic go();
    repeat (4) @(negedge clk);
  endtask

  function automatic int bits_lo(input logic [1:0] m);
    return m[0] ? 1 : 0;
  endfunction
  function automatic int bits_hi(input logic [1:0] m);
    return m[1] ? 1 : 0;
  endfunction

  task automatic do_access(input logic [9:0] row, input logic [9:0] col, input logic [1:0] mask,
                           input bit is_wr, input int npage, input bit late);
    int c0, cl, w0, w1;
    c0 = mon_cyc;
    addr = row; oe_n = 1'b1; we_n = 1'b1; ras_n = 1'b0;
    go();
    chk("R3 valid count", mon_cyc, c0 + 1);
    chk("R3 kind", mon_kind, 1);
    chk("R3 row", mon_row, row);
    chk("R10 busy on row", cycle_busy, 1);
    chk("R10 row only no drive", lane_drive, 0);
    for (int p = 0; p < npage; p++) begin
      cl = mon_col; w0 = mon_wr0; w1 = mon_wr1;
      addr = col + 10'(p);
      if (is_wr && !late) we_n = 1'b0;
      if (!is_wr) oe_n = 1'b0;
      {ucas_n, lcas_n} = ~mask;
      go();
      chk("R8 col pulse", mon_col, cl + 1);
      chk("R8 col value", col_out, int'(col + 10'(p)));
      chk("R2 merged on", cas_merged, 1);
      if (is_wr) begin
        if (late) begin
          chk("R9 no pulse before WE", mon_wr0 + mon_wr1, w0 + w1);
          we_n = 1'b0;
          go();
        end
        chk("R9 lane0 pulses", mon_wr0, w0 + bits_lo(mask));
        chk("R9 lane1 pulses", mon_wr1, w1 + bits_hi(mask));
        chk("R9 no drive on write", lane_drive, 0);
      end else begin
        chk("R7 drive mask", lane_drive, mask);
        oe_n = 1'b1;
        go();
        chk("R7 OE release", lane_drive, 0);
        oe_n = 1'b0;
        go();
        chk("R7 drive again", lane_drive, mask);
      end
      {ucas_n, lcas_n} = 2'b11;
      if (late) we_n = 1'b1;
      go();
      chk("R7 release on CAS high", lane_drive, 0);
      chk("R2 merged off", cas_merged, 0);
    end
    ras_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    go();
    chk("R10 idle after access", cycle_busy, 0);
  endtask

  task automatic do_cbr(input logic [1:0] mask);
    int c0;
    c0 = mon_cyc;
    addr = 10'($urandom); oe_n = 1'b0; we_n = 1'b1;
    {ucas_n, lcas_n} = ~mask;
    go();
    chk("R10 busy on CAS only", cycle_busy, 1);
    chk("R4 no drive before RAS", lane_drive, 0);
    ras_n = 1'b0;
    go();
    chk("R4 valid count", mon_cyc, c0 + 1);
    chk("R4 kind", mon_kind, 2);
    chk("R4 row from counter", mon_row, exp_ctr);
    chk("R4 no drive", lane_drive, 0);
    ras_n = 1'b1;
    go();
    exp_ctr = exp_ctr + 10'd1;
    chk("R5 counter step", refresh_row, exp_ctr);
    {ucas_n, lcas_n} = 2'b11; oe_n = 1'b1;
    go();
    chk("R10 idle after refresh", cycle_busy, 0);
  endtask

  task automatic do_hidden(input logic [9:0] row, input logic [9:0] col, input logic [1:0] mask);
    int c0;
    addr = row; oe_n = 1'b1; we_n = 1'b1; ras_n = 1'b0;
    go();
    addr = col; oe_n = 1'b0; {ucas_n, lcas_n} = ~mask;
    go();
    chk("R7 hidden pre-read drive", lane_drive, mask);
    ras_n = 1'b1;
    go();
    chk("R6 drive across RAS high", lane_drive, mask);
    chk("R10 busy with CAS held", cycle_busy, 1);
    chk("R5 no step after access", refresh_row, exp_ctr);
    c0 = mon_cyc;
    addr = 10'($urandom); ras_n = 1'b0;
    go();
    chk("R6 valid count", mon_cyc, c0 + 1);
    chk("R6 kind", mon_kind, 3);
    chk("R6 row from counter", mon_row, exp_ctr);
    chk("R6 drive during refresh", lane_drive, mask);
    ras_n = 1'b1;
    go();
    exp_ctr = exp_ctr + 10'd1;
    chk("R5 step after hidden", refresh_row, exp_ctr);
    {ucas_n, lcas_n} = 2'b11; oe_n = 1'b1;
    go();
    chk("R7 hidden release", lane_drive, 0);
    chk("R10 idle after hidden", cycle_busy, 0);
  endtask

  initial begin
    void'($urandom(32'h0DEC_0DE5));
    rst_n = 1'b0; ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1;
    we_n = 1'b1; oe_n = 1'b1; addr = 10'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    chk("R1 drive idle", lane_drive, 0);
    chk("R1 write idle", lane_write, 0);
    chk("R1 valid idle", cyc_valid, 0);
    chk("R1 col idle", col_load, 0);
    chk("R1 merged idle", cas_merged, 0);
    chk("R1 busy idle", cycle_busy, 0);
    chk("R1 kind reset", cyc_kind, 0);
    chk("R1 counter reset", refresh_row, 0);

    // R2 staggered column strobes
    ras_n = 1'b0; addr = 10'h155; go();
    lcas_n = 1'b0; go();
    chk("R2 first CAS low", cas_merged, 1);
    ucas_n = 1'b0; go();
    lcas_n = 1'b1; go();
    chk("R2 one CAS still low", cas_merged, 1);
    ucas_n = 1'b1; go();
    chk("R2 last CAS high", cas_merged, 0);
    ras_n = 1'b1; go();
    chk("R10 idle after stagger", cycle_busy, 0);

    // R10 row-only cycle with OE low
    oe_n = 1'b0; addr = 10'h2AA; ras_n = 1'b0; go();
    chk("R3 row-only kind", mon_kind, 1);
    chk("R3 row-only row", mon_row, 10'h2AA);
    chk("R10 row-only no drive", lane_drive, 0);
    ras_n = 1'b1; oe_n = 1'b1; go();

    do_access(10'h3FF, 10'h010, 2'b11, 1'b0, 2, 1'b0);
    do_access(10'h001, 10'h200, 2'b01, 1'b1, 2, 1'b0);
    do_access(10'h0F0, 10'h033, 2'b10, 1'b1, 1, 1'b1);
    do_cbr(2'b01);
    do_hidden(10'h123, 10'h045, 2'b10);

    for (int i = 0; i < 70; i++) begin
      logic [1:0] m;
      m = 2'($urandom_range(1, 3));
      case ($urandom_range(0, 4))
        0: do_access(10'($urandom), 10'($urandom), m, 1'b0, $urandom_range(1, 3), 1'b0);
        1: do_access(10'($urandom), 10'($urandom), m, 1'b1, $urandom_range(1, 3), 1'b0);
        2: do_access(10'($urandom), 10'($urandom), m, 1'b1, 1, 1'b1);
        3: do_cbr(m);
        default: do_hidden(10'($urandom), 10'($urandom), m);
      endcase
    end

    // R5 wrap of the refresh counter
    begin
      int n;
      n = 1024 - int'(exp_ctr);
      for (int k = 0; k < n; k++) do_cbr(2'b11);
      chk("R5 wrap to zero", refresh_row, 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule